// File: doc/BRIEF.md
# Serial receiver with flow control

This block is the receive half of one asynchronous serial channel. It watches the line input on each pulse of a strobe that runs at sixteen times the bit rate. It qualifies a start bit at the middle of the bit and samples every later bit at its centre. It builds characters of five to eight data bits, with a parity bit if one is configured. Each finished character goes into a three-entry queue together with its own parity, framing and break flags.

A host reads characters through a pop strobe. It learns the receiver state from an eight-bit status word and an interrupt request, and it controls the channel with single-cycle command strobes. When the queue fills, the block can hold off the far end by driving an active-low request-to-send output. A fourth character that arrives while the queue is full is parked in the assembly register, and overrun is flagged. If further characters arrive before the host reads, each one replaces the parked character.

Top module: `serial_rx_fc`

## Requirements
- R1: After reset, status is 0x00, irq is 0, rts_n is 0 and the receiver is disabled, so a character sent before an enable command is not received.
- R2: char_len selects the data length (0 = five bits, 1 = six, 2 = seven, 3 = eight). Data bits arrive least significant first, and unused upper bits of rd_data read as zero.
- R3: When par_mode is not 2, one parity bit follows the data. Mode 0 checks for even parity when par_odd is 0 and odd parity when par_odd is 1. Mode 1 expects the parity bit to equal par_odd. Mode 3 never reports a parity error. A mismatch sets status bit 5 for that character.
- R4: A low pulse on rxd that ends before the eighth sample of the start bit is ignored, and the receiver stays ready for the next real character.
- R5: A character whose stop bit is sampled low carries a framing error, shown in status bit 6.
- R6: A character whose data bits, parity bit (if present) and stop bit are all low carries the break flag in status bit 7, along with framing. brk_chg goes high when the break is received and again when the line returns high. No further character is assembled while the line stays low. cmd_clr_brk clears brk_chg.
- R7: Up to three characters are queued in arrival order. Status bit 0 is high while at least one is queued, and status bit 1 is high while three are queued.
- R8: A character that completes while the queue is full sets status bit 4 and is parked; later ones replace it. On the next pop the parked character enters the queue behind the others.
- R9: With err_block at 0, status bits 7:5 show the flags of the character at the head of the queue.
- R10: With err_block at 1, status bits 7:5 collect the flags of every queued character until cmd_clr_err. cmd_clr_err also clears the overrun bit in either mode.
- R11: irq follows status bit 0 when irq_on_full is 0, and follows status bit 1 when irq_on_full is 1.
- R12: With rts_auto at 1, rts_n is high while the queue is full and low once there is room. With rts_auto at 0, rts_n stays low.
- R13: cmd_disable stops reception and cmd_enable restarts it. cmd_reset empties the queue, clears all status and leaves the receiver disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Sample strobe at sixteen times the bit rate |
| rxd | input | 1 | Serial line, idle high |
| char_len | input | 2 | Data length code |
| par_mode | input | 2 | Parity mode code |
| par_odd | input | 1 | Parity sense: odd/mark when 1, even/space when 0 |
| rts_auto | input | 1 | Enable automatic request-to-send |
| irq_on_full | input | 1 | Interrupt source: queue full when 1, data ready when 0 |
| err_block | input | 1 | Accumulate error flags when 1 |
| cmd_enable | input | 1 | Enable the receiver |
| cmd_disable | input | 1 | Disable the receiver |
| cmd_reset | input | 1 | Flush the queue, clear status, disable |
| cmd_clr_err | input | 1 | Clear overrun and accumulated errors |
| cmd_clr_brk | input | 1 | Clear the break-change indication |
| rd_pop | input | 1 | Remove the head character |
| rd_data | output | 8 | Data of the head character |
| status | output | 8 | Receiver status word |
| irq | output | 1 | Receive interrupt request |
| rts_n | output | 1 | Request-to-send, active low |
| brk_chg | output | 1 | Break started or ended |

## Verification
The hardest state to reach is the parked character. The queue must be full, a fourth character must finish, a fifth must replace it, and only then does a pop move the survivor into the queue. The bench sends five whole frames without reading any of them, then drains the queue and checks the order, expecting the fifth character where the fourth was. Break is reached by holding the line low for longer than a whole frame, so the receiver must refuse to start a new character until the line rises.

// File: rtl/serial_rx_fc.sv
`timescale 1ns/1ps
module serial_rx_fc #(
  parameter int DEPTH = 3,
  parameter int OVS   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rxd,
  input  logic [1:0] char_len,
  input  logic [1:0] par_mode,
  input  logic       par_odd,
  input  logic       rts_auto,
  input  logic       irq_on_full,
  input  logic       err_block,
  input  logic       cmd_enable,
  input  logic       cmd_disable,
  input  logic       cmd_reset,
  input  logic       cmd_clr_err,
  input  logic       cmd_clr_brk,
  input  logic       rd_pop,
  output logic [7:0] rd_data,
  output logic [7:0] status,
  output logic       irq,
  output logic       rts_n,
  output logic       brk_chg
);
  localparam int CW  = $clog2(OVS);
  localparam int PW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW  = $clog2(DEPTH + 1);
  localparam int MID = OVS / 2 - 1;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_WAITHI} st_t;

  st_t           st;
  logic [CW-1:0] sc;
  logic [2:0]    bi;
  logic [7:0]    sh;
  logic          pbit, en, holdv, ovr;
  logic [10:0]   mem [DEPTH];
  logic [10:0]   hold, pv;
  logic [PW-1:0] rp, wp;
  logic [NW-1:0] cnt;
  logic [2:0]    acc;
  logic          push;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  wire [2:0] last    = 3'd4 + {1'b0, char_len};
  wire       has_par = (par_mode != 2'b10);
  wire       bit_end = tick16 && (sc == CW'(OVS - 1));
  wire       done    = en && !cmd_reset && (st == S_STOP) && bit_end;
  wire       pe      = (par_mode == 2'b00) ? ((^sh ^ pbit) != par_odd) :
                       (par_mode == 2'b01) ? (pbit != par_odd) : 1'b0;
  wire       brk     = (sh == 8'd0) && !rxd && !(has_par && pbit);
  wire [10:0] newc   = {brk, !rxd, pe, sh};
  wire       full    = (cnt == NW'(DEPTH));
  wire       nempty  = (cnt != '0);
  wire       do_pop  = rd_pop && nempty;
  wire       to_hold = done && full && !(!holdv && do_pop);
  wire       brk_end = en && (st == S_WAITHI) && tick16 && rxd;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) en <= 1'b0;
    else if (cmd_reset || cmd_disable) en <= 1'b0;
    else if (cmd_enable) en <= 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sc <= '0; bi <= '0; sh <= '0; pbit <= 1'b0;
    end else if (cmd_reset || !en) begin
      st <= S_IDLE;
    end else if (tick16) begin
      case (st)
        S_IDLE: if (!rxd) begin
          st <= S_START; sc <= CW'(1); sh <= '0; pbit <= 1'b0; bi <= '0;
        end
        S_START: if (sc == CW'(MID)) begin
          st <= rxd ? S_IDLE : S_DATA; sc <= '0;
        end else sc <= sc + 1'b1;
        S_DATA: if (bit_end) begin
          sh[bi] <= rxd; sc <= '0; bi <= bi + 1'b1;
          if (bi == last) st <= has_par ? S_PAR : S_STOP;
        end else sc <= sc + 1'b1;
        S_PAR: if (bit_end) begin
          pbit <= rxd; sc <= '0; st <= S_STOP;
        end else sc <= sc + 1'b1;
        S_STOP: if (bit_end) begin
          sc <= '0; st <= brk ? S_WAITHI : S_IDLE;
        end else sc <= sc + 1'b1;
        S_WAITHI: if (rxd) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) brk_chg <= 1'b0;
    else if ((done && brk) || brk_end) brk_chg <= 1'b1;
    else if (cmd_clr_brk) brk_chg <= 1'b0;

  always_comb begin
    push = 1'b0;
    pv   = newc;
    if (holdv && do_pop) begin
      push = 1'b1;
      pv   = hold;
    end else if (done && (!full || do_pop)) push = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= pv;
    if (to_hold) hold <= newc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp <= '0; wp <= '0; cnt <= '0; holdv <= 1'b0; ovr <= 1'b0; acc <= '0;
    end else if (cmd_reset) begin
      rp <= '0; wp <= '0; cnt <= '0; holdv <= 1'b0; ovr <= 1'b0; acc <= '0;
    end else begin
      if (do_pop) rp <= nxt(rp);
      if (push) wp <= nxt(wp);
      cnt <= cnt + NW'(push) - NW'(do_pop);
      acc <= (cmd_clr_err ? 3'b000 : acc) | (push ? pv[10:8] : 3'b000);
      ovr <= (ovr && !cmd_clr_err) || to_hold;
      if (to_hold) holdv <= 1'b1;
      else if (holdv && do_pop) holdv <= 1'b0;
    end
  end

  wire [2:0] head_f = nempty ? mem[rp][10:8] : 3'b000;
  assign rd_data = mem[rp][7:0];
  assign status  = {err_block ? acc : head_f, ovr, 2'b00, full, nempty};
  assign irq     = irq_on_full ? full : nempty;
  assign rts_n   = rts_auto && full;

  assert_depth_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= NW'(DEPTH));
  assert_pop_shrinks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pop && !push && !cmd_reset) |=> (cnt == $past(cnt) - NW'(1)));
  assert_park_only_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    holdv |-> full);
  assert_overrun_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> full);
  assert_reset_flush_R13: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |=> (cnt == '0 && !holdv && !en && !ovr));
  assert_break_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAITHI && !rxd) |=> (st == S_WAITHI || st == S_IDLE) && !done);
endmodule

// File: tb/serial_rx_fc_test.sv
`timescale 1ns/1ps
module serial_rx_fc_test;
  logic clk = 1'b0, rst_n = 1'b0, tick16 = 1'b1, rxd = 1'b1;
  logic [1:0] char_len = 2'd3, par_mode = 2'd2;
  logic par_odd = 1'b0, rts_auto = 1'b0, irq_on_full = 1'b0, err_block = 1'b0;
  logic cmd_enable = 1'b0, cmd_disable = 1'b0, cmd_reset = 1'b0, cmd_clr_err = 1'b0, cmd_clr_brk = 1'b0;
  logic rd_pop = 1'b0;
  logic [7:0] rd_data, status;
  logic irq, rts_n, brk_chg;
  int checks = 0, fails = 0;

  serial_rx_fc uut (.clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
    .char_len(char_len), .par_mode(par_mode), .par_odd(par_odd), .rts_auto(rts_auto),
    .irq_on_full(irq_on_full), .err_block(err_block), .cmd_enable(cmd_enable),
    .cmd_disable(cmd_disable), .cmd_reset(cmd_reset), .cmd_clr_err(cmd_clr_err),
    .cmd_clr_brk(cmd_clr_brk), .rd_pop(rd_pop), .rd_data(rd_data), .status(status),
    .irq(irq), .rts_n(rts_n), .brk_chg(brk_chg));

  always #2.5 clk = ~clk;

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finished");
    summary();
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n); repeat (n) @(negedge clk); endtask
  task automatic bitx(input logic b); rxd = b; idle(16); endtask

  task automatic frame(input logic [7:0] d, input int nb, input int pb, input logic stp);
    bitx(1'b0);
    for (int i = 0; i < nb; i++) bitx(d[i]);
    if (pb >= 0) bitx(pb[0]);
    rxd = stp;
    idle(stp ? 16 : 8);
    rxd = 1'b1;
    idle(20);
  endtask

  task automatic cmd(input int which);
    case (which)
      0: cmd_enable = 1'b1;
      1: cmd_disable = 1'b1;
      2: cmd_reset = 1'b1;
      3: cmd_clr_err = 1'b1;
      default: cmd_clr_brk = 1'b1;
    endcase
    idle(1);
    {cmd_enable, cmd_disable, cmd_reset, cmd_clr_err, cmd_clr_brk} = '0;
    idle(1);
  endtask

  task automatic pop(); rd_pop = 1'b1; idle(1); rd_pop = 1'b0; idle(1); endtask

  task automatic t_reset();
    chk("R1 status", status, 8'h00);
    chk("R1 irq", irq, 0);
    chk("R1 rts_n", rts_n, 0);
    frame(8'h5A, 8, -1, 1'b1);
    chk("R1 disabled after reset", status, 8'h00);
    cmd(0);
  endtask

  task automatic t_length();
    frame(8'hA5, 8, -1, 1'b1); chk("R2 8 bit", rd_data, 8'hA5); chk("R2 status", status, 8'h01); pop();
    char_len = 2'd0; frame(8'hF5, 5, -1, 1'b1); chk("R2 5 bit", rd_data, 8'h15); pop();
    char_len = 2'd2; frame(8'hDA, 7, -1, 1'b1); chk("R2 7 bit", rd_data, 8'h5A); pop();
    char_len = 2'd1; frame(8'h2C, 6, -1, 1'b1); chk("R2 6 bit", rd_data, 8'h2C); pop();
    char_len = 2'd3;
  endtask

  task automatic t_parity();
    par_mode = 2'd0; par_odd = 1'b0;
    frame(8'h03, 8, 0, 1'b1); chk("R3 even ok", status, 8'h01); pop();
    frame(8'h03, 8, 1, 1'b1); chk("R3 even bad", status, 8'h21); pop();
    par_odd = 1'b1;
    frame(8'h03, 8, 1, 1'b1); chk("R3 odd ok", status, 8'h01); pop();
    par_mode = 2'd1;
    frame(8'h00, 8, 0, 1'b1); chk("R3 forced mismatch", status, 8'h21); pop();
    frame(8'h00, 8, 1, 1'b1); chk("R3 forced match", status, 8'h01); pop();
    par_mode = 2'd3;
    frame(8'h07, 8, 0, 1'b1); chk("R3 multidrop status", status, 8'h01); chk("R3 multidrop data", rd_data, 8'h07); pop();
    par_mode = 2'd2; par_odd = 1'b0;
  endtask

  task automatic t_glitch();
    rxd = 1'b0; idle(5); rxd = 1'b1; idle(40);
    chk("R4 glitch ignored", status, 8'h00);
    frame(8'h3C, 8, -1, 1'b1); chk("R4 recovered", rd_data, 8'h3C); pop();
  endtask

  task automatic t_framing();
    frame(8'h55, 8, -1, 1'b0);
    chk("R5 framing status", status, 8'h41);
    chk("R5 framing data", rd_data, 8'h55);
    pop();
  endtask

  task automatic t_break();
    rxd = 1'b0; idle(200);
    chk("R6 break status", status, 8'hC1);
    chk("R6 brk_chg start", brk_chg, 1);
    cmd(4);
    chk("R6 brk_chg cleared", brk_chg, 0);
    idle(100);
    chk("R6 no char while low", status[1:0], 2'b01);
    rxd = 1'b1; idle(20);
    chk("R6 brk_chg end", brk_chg, 1);
    pop(); cmd(4);
    chk("R6 brk_chg cleared again", brk_chg, 0);
    chk("R6 empty", status, 8'h00);
  endtask

  task automatic t_fifo();
    rts_auto = 1'b1;
    frame(8'h11, 8, -1, 1'b1);
    chk("R11 irq ready", irq, 1); chk("R12 rts room", rts_n, 0);
    irq_on_full = 1'b1; idle(1);
    chk("R11 irq full src", irq, 0);
    frame(8'h22, 8, -1, 1'b1); frame(8'h33, 8, -1, 1'b1);
    chk("R7 full status", status, 8'h03);
    chk("R11 irq on full", irq, 1);
    chk("R12 rts negated", rts_n, 1);
    rts_auto = 1'b0; idle(1); chk("R12 rts manual", rts_n, 0);
    rts_auto = 1'b1; idle(1);
    chk("R7 order 1", rd_data, 8'h11); pop();
    chk("R12 rts reasserted", rts_n, 0);
    chk("R7 order 2", rd_data, 8'h22); pop();
    chk("R7 order 3", rd_data, 8'h33); pop();
    chk("R7 empty", status, 8'h00);
    irq_on_full = 1'b0; rts_auto = 1'b0;
  endtask

  task automatic t_overrun();
    frame(8'h11, 8, -1, 1'b1); frame(8'h22, 8, -1, 1'b1);
    frame(8'h33, 8, -1, 1'b1); frame(8'h44, 8, -1, 1'b1);
    chk("R8 overrun", status, 8'h13);
    frame(8'h55, 8, -1, 1'b1);
    chk("R8 head", rd_data, 8'h11); pop();
    chk("R8 parked entered", status, 8'h13);
    chk("R8 order 2", rd_data, 8'h22); pop();
    chk("R8 order 3", rd_data, 8'h33); pop();
    chk("R8 replaced parked", rd_data, 8'h55); pop();
    chk("R8 sticky overrun", status, 8'h10);
    cmd(3);
    chk("R10 clr_err clears overrun", status, 8'h00);
  endtask

  task automatic t_errmode();
    par_mode = 2'd0; par_odd = 1'b0;
    frame(8'h03, 8, 1, 1'b1); frame(8'h03, 8, 0, 1'b1);
    chk("R9 head flagged", status, 8'h21); pop();
    chk("R9 next clean", status, 8'h01); pop();
    err_block = 1'b1;
    frame(8'h03, 8, 1, 1'b1); frame(8'h03, 8, 0, 1'b1);
    chk("R10 block status", status, 8'h21); pop();
    chk("R10 accumulated", status, 8'h21);
    cmd(3);
    chk("R10 cleared", status, 8'h01); pop();
    err_block = 1'b0; par_mode = 2'd2;
  endtask

  task automatic t_cmds();
    cmd(1);
    frame(8'h77, 8, -1, 1'b1); chk("R13 disabled", status, 8'h00);
    cmd(0);
    frame(8'h66, 8, -1, 1'b1); frame(8'h67, 8, -1, 1'b1);
    chk("R13 enabled", status, 8'h01);
    cmd(2);
    chk("R13 reset flush", status, 8'h00);
    frame(8'h68, 8, -1, 1'b1); chk("R13 reset disables", status, 8'h00);
    cmd(0);
    frame(8'h69, 8, -1, 1'b1); chk("R13 re-enabled", rd_data, 8'h69); pop();
  endtask

  initial begin
    idle(4); rst_n = 1'b1; idle(2);
    t_reset();
    t_length();
    t_parity();
    t_glitch();
    t_framing();
    t_break();
    t_fifo();
    t_overrun();
    t_errmode();
    t_cmds();
    summary();
    $finish;
  end
endmodule